// File: doc/BRIEF.md
# Buffered Asynchronous Character Transmitter

This block turns parallel characters from a processor into asynchronous serial frames. A character that the processor writes lands in a one-entry holding register. It moves into a separate shift stage when that stage is free, or in the tick on which the previous frame's last stop interval ends. While one frame goes out on the line, the next character can already be waiting, which gives one character of buffering.

The frame shape comes from static configuration inputs. These set the character length (5 to 8 bits), whether a parity bit is sent and its sense, the stop interval (1, 1.5 or 2 bits) and the bit-clock multiple. Bit timing comes from a single-cycle clock-enable pulse at 1, 2, 16 or 64 times the baud rate. A new frame starts only when the enable input is high, the active-low clear-to-send input is low and no break is being forced. A break input holds the line low for as long as it stays asserted. A ready output tells the processor when the holding register is free. An empty output tells it that the line is idle and marking.

Top module: `sertx_core`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `tx_rdy` is 1 and `tx_empty` is 1.
- R2: A write (`wr_en` high) while `tx_rdy` is 1 captures `wr_data` and clears `tx_rdy` on the next clock. `tx_rdy` returns to 1 when the character moves into the shift stage. A write while `tx_rdy` is 0 is ignored: the character already held is the one that is sent, and no extra frame follows it.
- R3: A frame starts with one low start bit, followed by the data bits least significant first. `len_code` 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits of `wr_data` above the chosen length are not sent.
- R4: When `par_en` is 1, a parity bit follows the data. With `par_odd` = 0 the data bits plus the parity bit hold an even number of ones. With `par_odd` = 1 they hold an odd number.
- R5: Each bit lasts M clock-enable ticks. `rate_code` 0, 1, 2 and 3 give M = 1, 2, 16 and 64. The stop interval is high and lasts M ticks for `stop_code` 0 or 1, and 2M ticks for `stop_code` 3.
- R6: `stop_code` 2 gives a stop interval of 1.5 bits (24 ticks at M = 16). At M = 1 and M = 2 it lasts M ticks, the same as a single stop bit.
- R7: A frame starts only while `tx_en` is 1 and `cts_n` is 0. A frame that has already started completes unchanged if either input changes during it.
- R8: If a character is waiting when a stop interval ends and the gating conditions allow it, the next start bit follows at once, with no idle time on the line.
- R9: `tx_empty` is 1 while no frame is in progress and no break is forced, and 0 while a frame is being sent.
- R10: While `send_break` is 1, `txd` is 0 from the next clock on and no new frame starts. A character that is waiting is sent after the break is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Single-cycle bit-clock enable at M times the baud rate |
| tx_en | input | 1 | Transmitter enable |
| cts_n | input | 1 | Clear to send, active low |
| send_break | input | 1 | Force the line low |
| len_code | input | 2 | Character length code (5 + code bits) |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_code | input | 2 | Stop interval: 0/1 one bit, 2 one and a half bits, 3 two bits |
| rate_code | input | 2 | Bit-clock multiple: 0 1X, 1 2X, 2 16X, 3 64X |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, idles high |
| tx_rdy | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | No frame in progress and the line is marking |

## Verification
The assertions assume three things about the inputs. `clk_en` is a one-cycle pulse. The shape inputs (`len_code`, `par_en`, `par_odd`, `stop_code`, `rate_code`) stay still while a frame is in flight. A write is not issued in the same cycle as reset. The bench produces the enable on every second clock. It changes the shape inputs only after both `tx_empty` and `tx_rdy` show the transmitter idle. Only the gating inputs (`cts_n`, `tx_en`, `send_break`) are toggled during activity, and those are the cases R7 and R10 cover.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } txst_e;

  // Mask keeping the low (5 + code) bits of a character.
  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] code);
    return 8'hFF >> (2'd3 - code);
  endfunction

endpackage

// File: rtl/sertx_pace.sv
module sertx_pace #(
  parameter int CNT_W = 8,
  parameter int MUL1  = 2,
  parameter int MUL2  = 16,
  parameter int MUL3  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rate_code,
  input  logic [1:0]       stop_code,
  output logic [CNT_W-1:0] bit_ticks,
  output logic [CNT_W-1:0] stop_ticks
);

  localparam logic [CNT_W-1:0] M0 = CNT_W'(1);
  localparam logic [CNT_W-1:0] M1 = CNT_W'(MUL1);
  localparam logic [CNT_W-1:0] M2 = CNT_W'(MUL2);
  localparam logic [CNT_W-1:0] M3 = CNT_W'(MUL3);

  logic [CNT_W-1:0] mult;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] stop_n;

  always_comb begin
    case (rate_code)
      2'd0:    mult = M0;
      2'd1:    mult = M1;
      2'd2:    mult = M2;
      default: mult = M3;
    endcase
    half = mult >> 1;
    case (stop_code)
      2'd2:    stop_n = (mult > CNT_W'(2)) ? (mult + half) : mult;
      2'd3:    stop_n = mult << 1;
      default: stop_n = mult;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_ticks  <= M0;
      stop_ticks <= M0;
    end else begin
      bit_ticks  <= mult;
      stop_ticks <= stop_n;
    end
  end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              take,
  output logic              hold_full,
  output logic [CHAR_W-1:0] hold_data,
  output logic              rdy
);

  logic              free_q;
  logic [CHAR_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= 1'b1;
      data_q <= '0;
    end else if (take) begin
      free_q <= 1'b1;
    end else if (wr_en && free_q) begin
      free_q <= 1'b0;
      data_q <= wr_data;
    end
  end

  assign hold_full = ~free_q;
  assign hold_data = data_q;
  assign rdy       = free_q;

  // A held character must not change until it is taken.
  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!free_q && !take) |=> $stable(data_q));

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              go_ok,
  input  logic              hold_full,
  input  logic [CHAR_W-1:0] hold_data,
  input  logic [1:0]        len_code,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [CNT_W-1:0]  bit_ticks,
  input  logic [CNT_W-1:0]  stop_ticks,
  output logic              take,
  output logic              busy,
  output logic              line_bit
);

  txst_e             st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CHAR_W-1:0] sh_q;
  logic [2:0]        nbit_q;
  logic              par_q;

  logic [CNT_W-1:0]  phase_len;
  logic              phase_end;
  logic              char_par;

  always_comb begin
    phase_len = (st_q == S_STOP) ? stop_ticks : bit_ticks;
    phase_end = tick && (cnt_q == phase_len - CNT_W'(1));
    take      = go_ok && hold_full && tick &&
                ((st_q == S_IDLE) || ((st_q == S_STOP) && phase_end));
    char_par  = (^(hold_data & len_mask(len_code))) ^ par_odd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      nbit_q <= '0;
      par_q  <= 1'b0;
    end else if (take) begin
      st_q   <= S_START;
      cnt_q  <= '0;
      sh_q   <= hold_data;
      nbit_q <= 3'(len_code) + 3'd4;
      par_q  <= char_par;
    end else if (tick && (st_q != S_IDLE)) begin
      if (phase_end) begin
        cnt_q <= '0;
        case (st_q)
          S_START: st_q <= S_DATA;
          S_DATA: begin
            sh_q <= sh_q >> 1;
            if (nbit_q == 3'd0) st_q <= par_en ? S_PAR : S_STOP;
            else                nbit_q <= nbit_q - 3'd1;
          end
          S_PAR:   st_q <= S_STOP;
          default: st_q <= S_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  always_comb begin
    case (st_q)
      S_START: line_bit = 1'b0;
      S_DATA:  line_bit = sh_q[0];
      S_PAR:   line_bit = par_q;
      default: line_bit = 1'b1;
    endcase
  end

  assign busy = (st_q != S_IDLE);

  // An idle shifter stays idle while the gating conditions are not met.
  assert_gate_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && !go_ok) |=> (st_q == S_IDLE));

  // Leaving idle always enters the start bit first.
  assert_start_first_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q != S_IDLE && $past(st_q) == S_IDLE) |-> (st_q == S_START));

endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
  parameter int CNT_W = 8,
  parameter int MUL1  = 2,
  parameter int MUL2  = 16,
  parameter int MUL3  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clk_en,
  input  logic       tx_en,
  input  logic       cts_n,
  input  logic       send_break,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [1:0] stop_code,
  input  logic [1:0] rate_code,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       tx_rdy,
  output logic       tx_empty
);

  logic [CNT_W-1:0] bit_ticks;
  logic [CNT_W-1:0] stop_ticks;
  logic             take;
  logic             hold_full;
  logic [7:0]       hold_data;
  logic             busy;
  logic             line_bit;
  logic             go_ok;
  logic             txd_q;
  logic             empty_q;

  assign go_ok = tx_en && !cts_n && !send_break;

  sertx_pace #(
    .CNT_W (CNT_W),
    .MUL1  (MUL1),
    .MUL2  (MUL2),
    .MUL3  (MUL3)
  ) u_pace (
    .clk        (clk),
    .rst        (rst),
    .rate_code  (rate_code),
    .stop_code  (stop_code),
    .bit_ticks  (bit_ticks),
    .stop_ticks (stop_ticks)
  );

  sertx_hold u_hold (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (take),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .rdy       (tx_rdy)
  );

  sertx_frame #(
    .CNT_W (CNT_W)
  ) u_frame (
    .clk        (clk),
    .rst        (rst),
    .tick       (clk_en),
    .go_ok      (go_ok),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .len_code   (len_code),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .bit_ticks  (bit_ticks),
    .stop_ticks (stop_ticks),
    .take       (take),
    .busy       (busy),
    .line_bit   (line_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_q   <= 1'b1;
      empty_q <= 1'b1;
    end else begin
      txd_q   <= send_break ? 1'b0 : line_bit;
      empty_q <= !busy && !send_break;
    end
  end

  assign txd      = txd_q;
  assign tx_empty = empty_q;

  assert_break_low_R10: assert property (@(posedge clk) disable iff (rst)
    send_break |=> !txd);

  assert_empty_marks_R9: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd);

endmodule

// File: tb/sertx_core_tb.sv
`timescale 1ns/1ps
module sertx_core_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b0;
  logic       tx_en = 1'b0;
  logic       cts_n = 1'b1;
  logic       send_break = 1'b0;
  logic [1:0] len_code = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [1:0] stop_code = 2'd1;
  logic [1:0] rate_code = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd;
  logic       tx_rdy;
  logic       tx_empty;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      clk_en = ~clk_en;
    end
  end

  sertx_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .tx_en      (tx_en),
    .cts_n      (cts_n),
    .send_break (send_break),
    .len_code   (len_code),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .stop_code  (stop_code),
    .rate_code  (rate_code),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .txd        (txd),
    .tx_rdy     (tx_rdy),
    .tx_empty   (tx_empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clocks_per_bit(input logic [1:0] r);
    case (r)
      2'd0:    return 2;
      2'd1:    return 4;
      2'd2:    return 32;
      default: return 128;
    endcase
  endfunction

  task automatic set_shape(input logic [1:0] rc, input logic [1:0] lc,
                           input logic pe, input logic po, input logic [1:0] sc);
    @(negedge clk);
    rate_code = rc; len_code = lc; par_en = pe; par_odd = po; stop_code = sc;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_char(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fall(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000 && !ok; i++) begin
      @(negedge clk);
      if (!txd) ok = 1'b1;
    end
  endtask

  task automatic wait_idle();
    bit ok = 1'b0;
    for (int i = 0; i < 20000 && !ok; i++) begin
      @(negedge clk);
      if (tx_empty && tx_rdy && txd) ok = 1'b1;
    end
    chk(ok, "R9", "return to idle", int'(ok), 1);
  endtask

  task automatic capture(input string req, input logic [7:0] exp, input bit drop_cts);
    int   m  = clocks_per_bit(rate_code);
    int   nb = int'(len_code) + 5;
    logic [7:0] mask = 8'((1 << nb) - 1);
    logic [7:0] got = 8'h00;
    logic pexp;
    bit   ok;
    wait_fall(ok);
    chk(ok, req, "start bit seen", int'(ok), 1);
    if (!ok) return;
    chk(tx_empty == 1'b0, "R9", "empty low in frame", int'(tx_empty), 0);
    repeat (m / 2) @(negedge clk);
    chk(txd == 1'b0, "R3", "start bit low", int'(txd), 0);
    if (drop_cts) begin cts_n = 1'b1; tx_en = 1'b0; end
    for (int i = 0; i < nb; i++) begin
      repeat (m) @(negedge clk);
      got[i] = txd;
    end
    chk(got == (exp & mask), req, "data bits", int'(got), int'(exp & mask));
    if (par_en) begin
      repeat (m) @(negedge clk);
      pexp = (^(exp & mask)) ^ par_odd;
      chk(txd == pexp, "R4", "parity bit", int'(txd), int'(pexp));
    end
    repeat (m) @(negedge clk);
    chk(txd == 1'b1, "R5", "stop high", int'(txd), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(txd == 1'b1,     "R1", "txd after reset",   int'(txd), 1);
    chk(tx_rdy == 1'b1,  "R1", "ready after reset", int'(tx_rdy), 1);
    chk(tx_empty == 1'b1,"R1", "empty after reset", int'(tx_empty), 1);
  endtask

  task automatic t_basic();
    set_shape(2'd0, 2'd3, 1'b0, 1'b0, 2'd1);
    write_char(8'hA5);
    chk(tx_rdy == 1'b0, "R2", "ready falls after write", int'(tx_rdy), 0);
    capture("R3", 8'hA5, 1'b0);
    wait_idle();
    chk(tx_rdy == 1'b1 && tx_empty == 1'b1, "R9", "idle flags after frame",
        int'({tx_rdy, tx_empty}), 3);
  endtask

  task automatic t_shapes();
    set_shape(2'd2, 2'd0, 1'b1, 1'b0, 2'd1);
    write_char(8'hF3);
    capture("R4", 8'hF3, 1'b0);
    wait_idle();
    set_shape(2'd1, 2'd2, 1'b1, 1'b1, 2'd1);
    write_char(8'h55);
    capture("R4", 8'h55, 1'b0);
    wait_idle();
    set_shape(2'd3, 2'd1, 1'b0, 1'b0, 2'd3);
    write_char(8'h2D);
    capture("R3", 8'h2D, 1'b0);
    wait_idle();
  endtask

  // Two zero characters back to back: the high run between them is the stop interval.
  task automatic t_stop(input string req, input logic [1:0] rc,
                        input logic [1:0] sc, input int exp_ticks);
    bit ok = 1'b0;
    int run = 0;
    set_shape(rc, 2'd3, 1'b0, 1'b0, sc);
    write_char(8'h00);
    for (int i = 0; i < 20000 && !ok; i++) begin
      @(negedge clk);
      if (tx_rdy) ok = 1'b1;
    end
    write_char(8'h00);
    wait_fall(ok);
    ok = 1'b0;
    for (int i = 0; i < 20000 && !ok; i++) begin
      @(negedge clk);
      if (txd) ok = 1'b1;
    end
    run = 1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!txd) break;
      run++;
    end
    chk(run == exp_ticks * 2, req, "stop run in clocks", run, exp_ticks * 2);
    chk(run == exp_ticks * 2, "R8", "no idle gap", run, exp_ticks * 2);
    wait_idle();
  endtask

  task automatic t_gate();
    int hi = 0;
    set_shape(2'd0, 2'd3, 1'b0, 1'b0, 2'd1);
    cts_n = 1'b1;
    write_char(8'h3C);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd && !tx_rdy && tx_empty) hi++;
    end
    chk(hi == 100, "R7", "held while cts high", hi, 100);
    write_char(8'hFF);
    cts_n = 1'b0;
    capture("R2", 8'h3C, 1'b0);
    wait_idle();
    hi = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd) hi++;
    end
    chk(hi == 200, "R2", "ignored write sends nothing", hi, 200);
    tx_en = 1'b0;
    write_char(8'h81);
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd) hi++;
    end
    chk(hi == 100, "R7", "held while disabled", hi, 100);
    tx_en = 1'b1;
    capture("R7", 8'h81, 1'b0);
    wait_idle();
  endtask

  task automatic t_midframe();
    set_shape(2'd1, 2'd3, 1'b1, 1'b0, 2'd1);
    write_char(8'h96);
    capture("R7", 8'h96, 1'b1);
    cts_n = 1'b0; tx_en = 1'b1;
    wait_idle();
  endtask

  task automatic t_break();
    int lo = 0;
    set_shape(2'd0, 2'd3, 1'b0, 1'b0, 2'd1);
    @(negedge clk);
    send_break = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R10", "line low in break", int'(txd), 0);
    chk(tx_empty == 1'b0, "R9", "empty low in break", int'(tx_empty), 0);
    write_char(8'h42);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!txd && !tx_rdy) lo++;
    end
    chk(lo == 50, "R10", "no frame during break", lo, 50);
    send_break = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R10", "line released", int'(txd), 1);
    capture("R10", 8'h42, 1'b0);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    tx_en = 1'b1;
    cts_n = 1'b0;
    t_basic();
    t_shapes();
    t_stop("R6", 2'd2, 2'd2, 24);
    t_stop("R5", 2'd2, 2'd3, 32);
    t_stop("R6", 2'd1, 2'd2, 2);
    t_stop("R5", 2'd3, 2'd1, 64);
    t_gate();
    t_midframe();
    t_break();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule